// File: doc/BRIEF.md
# Carry-Pipelined Segmented Accumulator

This block keeps a running unsigned total of a stream of words, taking one word per clock. The total is wide, but no adder in it is wider than one segment. The accumulator register is split into equal slices. The carry leaving each slice is caught in a flip-flop and enters the next slice up on the following clock, so the critical path is one short add.

The cost is that the concatenated slices are not an exact sum while any of those carry flip-flops holds a 1. To read the total, the user pulses a read request. The block then stops taking data and keeps stepping the slices with a zero addend until every carry flip-flop is empty. It then pulses result-valid for one cycle with the exact total on the output. Accumulation resumes from that total; the total is not restarted.

A synchronous clear zeroes everything in one clock.

Top module: `seg_accum`

## Requirements
- R1: `W` (total width) and `NSEG` (slice count, 2 to 4, dividing `W`) are parameters. Exactly `NSEG-1` carry flip-flops sit between adjacent slices. A carry leaving slice k enters slice k+1 one clock later, so a carry can need up to `NSEG-1` clocks to reach the top slice.
- R2: Outside a read-out, `in_ready` stays high. A word with `in_valid` high is accepted on every clock, back to back, with no stall.
- R3: When `out_valid` is high, `acc_out` equals the sum, modulo 2^W, of every accepted word since the last clear or reset. Any carry out of the top slice is discarded.
- R4: The last cycle of a read-out has every carry flip-flop empty, and `out_valid` rises at the end of that cycle. Counting the clock edge that samples `rd_req` as edge 0, `out_valid` is seen after edge k with 1 <= k <= `NSEG`. If no carry is pending, k = 1. If a carry must ripple through every slice, k = `NSEG`.
- R5: From the edge that samples `rd_req` until `out_valid` rises, `in_ready` is low. During that window, words offered with `in_valid` and further `rd_req` pulses have no effect on the total.
- R6: When `clr` is sampled high, all slices and carry flip-flops are zero on the next cycle. `out_valid` is low, `in_ready` is high, and any read-out in progress is abandoned. `clr` takes priority over `rd_req`.
- R7: After `rst`, `acc_out` is 0, `in_ready` is 1 and `out_valid` is 0.
- R8: `out_valid` is a single-cycle pulse, and `in_ready` is high during it. Accumulation after it continues from the reported total.
- R9: A word offered with `in_valid` in the same cycle as `rd_req`, while `in_ready` is high, is accepted and is included in that read-out's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the total |
| in_valid | input | 1 | Input word present |
| in_data | input | W | Unsigned word to add |
| rd_req | input | 1 | Read-out request |
| in_ready | output | 1 | Block accepts words (low during read-out) |
| acc_out | output | W | Concatenated slice registers |
| out_valid | output | 1 | One-cycle pulse: `acc_out` is exact |

## Verification
The properties assume `rst` and `clr` are single synchronous pulses. They also assume the environment samples `acc_out` only when `out_valid` is high, since in other cycles the value may be inexact by design. The stimulus drives every input at the falling edge. It decides whether a word counts only from the `in_ready` value seen in that cycle. It keeps offering junk words and repeated read requests throughout each flush window, so the rule that these are ignored is tested against the next reported total.

// File: rtl/seg_accum_pkg.sv
package seg_accum_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_FLUSH = 1'b1
  } acc_state_t;
endpackage

// File: rtl/seg_slice.sv
// One slice of the accumulator: a short adder, its sum register and,
// optionally, a registered carry towards the next slice.
module seg_slice #(
  parameter int SW         = 8,
  parameter bit KEEP_CARRY = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [SW-1:0] addend,
  input  logic          cin,
  output logic [SW-1:0] sum_q,
  output logic          cout_q
);
  logic [SW:0] nxt;

  always_comb begin
    nxt = {1'b0, sum_q} + {1'b0, addend} + {{SW{1'b0}}, cin};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= nxt[SW-1:0];
      // top slice: the carry leaves the modulo range and is dropped
      cout_q <= KEEP_CARRY ? nxt[SW] : 1'b0;
    end
  end
endmodule

// File: rtl/flush_ctrl.sv
// Read-out sequencer: stops intake and waits for the carry chain to drain.
module flush_ctrl
  import seg_accum_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic rd_req,
  input  logic carries_zero,
  output logic in_ready,
  output logic out_valid
);
  acc_state_t st, st_nxt;
  logic       done;

  always_comb begin
    st_nxt = st;
    done   = 1'b0;
    case (st)
      ST_RUN:   if (rd_req) st_nxt = ST_FLUSH;
      ST_FLUSH: if (carries_zero) begin
        st_nxt = ST_RUN;
        done   = 1'b1;
      end
      default:  st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st        <= ST_RUN;
      in_ready  <= 1'b1;
      out_valid <= 1'b0;
    end else begin
      st        <= st_nxt;
      in_ready  <= (st_nxt == ST_RUN);
      out_valid <= done;
    end
  end
endmodule

// File: rtl/seg_accum.sv
// Wide accumulator built from NSEG short slices with pipelined carries (R1).
module seg_accum #(
  parameter int W    = 32,
  parameter int NSEG = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         rd_req,
  output logic         in_ready,
  output logic [W-1:0] acc_out,
  output logic         out_valid
);
  localparam int SW = W / NSEG;

  logic         take;
  logic [W-1:0] addend;
  logic [NSEG:0] carry;
  logic         carries_zero;

  // during a flush the addend is forced to zero (R5)
  assign take   = in_valid & in_ready;
  assign addend = take ? in_data : '0;
  assign carry[0] = 1'b0;
  assign carries_zero = ~|carry[NSEG:1];

  for (genvar g = 0; g < NSEG; g++) begin : g_slice
    seg_slice #(
      .SW        (SW),
      .KEEP_CARRY(g < NSEG - 1)
    ) u_slice (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .addend(addend[g*SW +: SW]),
      .cin   (carry[g]),
      .sum_q (acc_out[g*SW +: SW]),
      .cout_q(carry[g+1])
    );
  end

  flush_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .rd_req      (rd_req),
    .carries_zero(carries_zero),
    .in_ready    (in_ready),
    .out_valid   (out_valid)
  );
endmodule

// File: rtl/seg_accum_chk.sv
module seg_accum_chk #(
  parameter int W    = 32,
  parameter int NSEG = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          rd_req,
  input logic          in_ready,
  input logic          out_valid,
  input logic [W-1:0]  acc_out,
  input logic [NSEG:0] carry
);
  localparam int CW = $clog2(NSEG + 2);
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || in_ready) busy_cnt <= '0;
    else if (busy_cnt < CW'(NSEG + 1)) busy_cnt <= busy_cnt + 1'b1;
  end

  a_r2_ready_holds: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !rd_req) |=> in_ready);
  a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (in_ready && rd_req && !clr) |=> !in_ready);
  a_r5_total_frozen: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && carry == '0 && !clr) |=> $stable(acc_out));
  a_r3_no_pending_carry: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (carry == '0));
  a_r4_flush_bound: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (busy_cnt < CW'(NSEG)));
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_out == '0 && !out_valid && in_ready));
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  a_r8_ready_with_valid: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);
endmodule

bind seg_accum seg_accum_chk #(.W(W), .NSEG(NSEG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr      (clr),
  .rd_req   (rd_req),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .acc_out  (acc_out),
  .carry    (carry)
);

// File: tb/seg_accum_test.sv
`timescale 1ns/1ps
module seg_accum_test;
  localparam int W    = 32;
  localparam int NSEG = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         rd_req = 1'b0;
  logic         in_ready;
  logic [W-1:0] acc_out;
  logic         out_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rd_cyc = 0;
  bit done = 1'b0;
  logic [W-1:0] sum = '0;
  logic [W-1:0] exp_q[$];
  int           lat_q[$];
  logic [31:0]  lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seg_accum #(.W(W), .NSEG(NSEG)) uut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_data(in_data),
    .rd_req(rd_req), .in_ready(in_ready), .acc_out(acc_out), .out_valid(out_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a result appears
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected result", 64'(acc_out), 64'hDEAD);
      end else begin
        logic [W-1:0] e;
        int lat, el;
        e   = exp_q.pop_front();
        el  = lat_q.pop_front();
        lat = cyc - rd_cyc;
        chk(acc_out == e, "R3 total", 64'(acc_out), 64'(e));
        chk(in_ready, "R8 ready with valid", 64'(in_ready), 64'd1);
        if (el > 0) chk(lat == el, "R4 flush latency", 64'(lat), 64'(el));
        else chk(lat >= 1 && lat <= NSEG, "R4 flush bound", 64'(lat), 64'(NSEG));
      end
    end
  end

  task automatic push(input logic [W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    if (in_ready) sum = sum + d;
    chk(in_ready, "R2 no stall", 64'(in_ready), 64'd1);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // read-out; optional word in the request cycle (R9); explat 0 = bound only
  task automatic readout(input bit v, input logic [W-1:0] d, input int explat);
    @(negedge clk);
    rd_req   = 1'b1;
    in_valid = v;
    in_data  = d;
    if (v && in_ready) sum = sum + d;
    exp_q.push_back(sum);
    lat_q.push_back(explat);
    rd_cyc = cyc + 1;
    for (int i = 0; i < NSEG + 4; i++) begin
      @(negedge clk);
      if (out_valid) break;
      // junk and repeated requests during flush must be ignored (R5)
      chk(!in_ready, "R5 ready low in flush", 64'(in_ready), 64'd0);
      in_valid = 1'b1;
      in_data  = 32'hABCD_0000 + i;
      rd_req   = 1'b1;
    end
    in_valid = 1'b0;
    rd_req   = 1'b0;
    @(negedge clk);
    chk(exp_q.size() == 0, "R3 result delivered", 64'(exp_q.size()), 64'd0);
    chk(!out_valid, "R8 single pulse", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(acc_out == '0, "R7 reset total", 64'(acc_out), 64'd0);
    chk(in_ready, "R7 reset ready", 64'(in_ready), 64'd1);
    chk(!out_valid, "R7 reset valid", 64'(out_valid), 64'd0);

    // small values, no carries pending: early result (R4)
    push(32'd5); push(32'd7); idle(); idle();
    readout(1'b0, '0, 1);

    // back-to-back random stream, continues from previous total (R2, R8)
    for (int i = 0; i < 40; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      push(lcg);
    end
    readout(1'b1, 32'h00FF_FF01, 0);   // word in request cycle counts (R9)

    // clear (R6)
    push(32'h1111_1111);
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    sum = '0;
    chk(acc_out == '0, "R6 clear total", 64'(acc_out), 64'd0);
    chk(in_ready && !out_valid, "R6 clear flags", {62'd0, in_ready, out_valid}, 64'd2);

    // worst-case ripple through every slice plus wrap (R1, R3, R4)
    push(32'hFFFF_FFFF); idle(); idle();
    readout(1'b1, 32'd1, NSEG);
    chk(sum == '0, "R3 modulo wrap model", 64'(sum), 64'd0);

    // patterns heavy in slice carries
    for (int i = 0; i < 30; i++) push(32'h80FF_7F81 + i);
    readout(1'b0, '0, 0);
    for (int i = 0; i < 16; i++) begin
      push(32'hFFFF_FFFF);
      idle();
    end
    readout(1'b1, 32'hFFFF_FFFF, 0);

    // clear abandons a read-out in progress (R6)
    push(32'hFF00_FF00); push(32'h01FF_01FF);
    @(negedge clk);
    in_valid = 1'b0;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    sum = '0;
    chk(in_ready && !out_valid && acc_out == '0, "R6 clear during flush",
        {30'd0, in_ready, out_valid, acc_out}, {32'd2, 32'd0});
    push(32'd9);
    readout(1'b0, '0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule